// File: doc/BRIEF.md
# Processor Cluster Control Register Block

This block is a 32-bit memory-mapped control and status register file for a cluster of four processor cores. Each core has a 64-bit reset vector base address, built from two 32-bit words. The block also holds a per-core power-down request and one error interrupt source. That source has a status register, a mask register and write-only enable and disable registers. A few more registers are plain storage for configuration, coherency control and snoop control, and they have no effect on the logic here.

Each core reports its wait-for-interrupt state on its own input. The block captures that input and gates it with the core's power-down request to form an idle output toward the power management unit. It drives the raw request as a power-status output toward an interrupt redirector. It also drives one interrupt line that goes high when the error status is set and unmasked. The register bus has one request per cycle. A read returns its data, with a valid strobe, one cycle after the request. Only aligned, full 32-bit accesses are accepted.

Top module: `cluster_ctrl_regs`

## Requirements
- R1: After reset the registers read as follows. Every low reset-vector word reads 0xFFFF0000 and every high word reads 0. Configuration 0 (0x20) reads 0x00000F0F, coherency control (0x60) reads 0x000F000F and the mask (0x14) reads 1. Every other register reads 0, and irq, wfi_out and pwr_status are low.
- R2: The reset-vector words sit from offset 0x40 as low/high pairs, core 0 first, so core i has its low word at 0x40+8i and its high word at 0x44+8i. core_rvbar[64i+63:64i] is the high word concatenated above the low word.
- R3: A write to power control (0x90) stores data bits [3:0] as the per-core power-down request. A read of 0x90 returns the request in bits [3:0] with zeros above it. pwr_status[i] equals request bit i from the clock edge after the write.
- R4: The block registers core_wfi_in on every clock edge. wfi_out[i] is the registered input of core i ANDed with request bit i, so it changes one cycle after either of them changes.
- R5: An err_pulse cycle sets status bit 0 (0x10). Writing 1 to bit 0 of 0x10 clears it. If a pulse and a clearing write fall in the same cycle, the bit ends up set.
- R6: irq is high exactly when status bit 0 is 1 and mask bit 0 is 0.
- R7: Bus writes to the mask (0x14) have no effect. Writing a 1 in bit 0 of enable (0x18) clears the mask, and writing a 1 in bit 0 of disable (0x1C) sets it. Both 0x18 and 0x1C read as 0.
- R8: Error control (0x00), configuration 0 and 1 (0x20, 0x24), coherency control (0x60) and snoop control (0x80) store and return all 32 bits.
- R9: An access with req_be other than 4'hF, or with req_addr[1:0] nonzero, changes no register. If it is a read, it returns 0.
- R10: Unmapped offsets read as 0 and ignore writes.
- R11: Power status (0x94) is read-only. Bits [3:0] return wfi_out, and the bits above them read 0.
- R12: Every read request, accepted or not, gives rd_valid high in the next cycle with its data on rd_data. rd_valid is low in any cycle that follows no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte enables; only 4'hF is accepted |
| req_addr | input | ADDR_W (8) | Byte offset |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 32 | Read data |
| err_pulse | input | 1 | One-cycle error event |
| core_wfi_in | input | NCORES (4) | Per-core wait-for-interrupt state |
| wfi_out | output | NCORES (4) | Per-core idle-and-requested indication |
| pwr_status | output | NCORES (4) | Per-core power-down request |
| irq | output | 1 | Error interrupt |
| core_rvbar | output | NCORES*64 (256) | Per-core 64-bit reset vector base |

## Verification
On every cycle the checker enforces several rules. A core's idle output never rises without that core's request. An error pulse always leaves the status bit set one cycle later, and irq never rises while the source is masked or clear. Every read gets exactly one acknowledge one cycle later. A partial-width write leaves the mask and the power requests untouched. The bench scenarios cover the rest. These are the reset values, the register layout of the vector pairs, the status readback, the ignored writes to the mask and to unmapped space, the one-cycle capture delay on the idle inputs, and the case where a set and a clear of the status bit fall in the same cycle.

// File: rtl/cc_pkg.sv
// Package: shared constants and types of the cluster control register block.
// Assumes byte offsets on a 32-bit word bus.
package cc_pkg;
    localparam int DATA_W = 32;

    // Byte offsets of the register map
    localparam int OFF_ERRCTL  = 'h00;
    localparam int OFF_ISR     = 'h10;
    localparam int OFF_IMR     = 'h14;
    localparam int OFF_IEN     = 'h18;
    localparam int OFF_IDS     = 'h1C;
    localparam int OFF_CFG0    = 'h20;
    localparam int OFF_CFG1    = 'h24;
    localparam int OFF_RVB     = 'h40;
    localparam int OFF_COH     = 'h60;
    localparam int OFF_SNOOP   = 'h80;
    localparam int OFF_PWRCTL  = 'h90;
    localparam int OFF_PWRSTAT = 'h94;

    // Reset values
    localparam logic [DATA_W-1:0] RST_RVB_LO = 32'hFFFF_0000;
    localparam logic [DATA_W-1:0] RST_CFG0   = 32'h0000_0F0F;
    localparam logic [DATA_W-1:0] RST_COH    = 32'h000F_000F;

    typedef enum logic [3:0] {
        RID_NONE,
        RID_ERRCTL,
        RID_ISR,
        RID_IMR,
        RID_IEN,
        RID_IDS,
        RID_CFG0,
        RID_CFG1,
        RID_RVB,
        RID_COH,
        RID_SNOOP,
        RID_PWRCTL,
        RID_PWRSTAT
    } reg_id_e;
endpackage

// File: rtl/cc_word_reg.sv
// Module: one storage word with a parameterised reset value.
// Assumes a write enable that is already qualified by the decoder.
module cc_word_reg #(
    parameter int                W   = 32,
    parameter logic [W-1:0]      RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Hold the word; load on write, restore on reset
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST;
        else if (we) q <= d;
    end
endmodule

// File: rtl/cc_bus_decode.sv
// Module: decodes one bus request into a register id and an access qualifier.
// Assumes one request per cycle; only aligned, all-bytes accesses are accepted.
module cc_bus_decode
    import cc_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int ADDR_W = 8,
    localparam int VIDX_W = $clog2(2 * NCORES)
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [3:0]        req_be,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              wr_ok,
    output logic              rd_ok,
    output logic              rd_req,
    output reg_id_e           rid,
    output logic [VIDX_W-1:0] vidx
);
    localparam int RVB_END = OFF_RVB + 8 * NCORES;

    logic full_word;

    // Qualify the access by size and alignment
    always_comb begin
        full_word = req_valid && (req_be == 4'hF) && (req_addr[1:0] == 2'b00);
        wr_ok     = full_word && req_write;
        rd_ok     = full_word && !req_write;
        rd_req    = req_valid && !req_write;
    end

    // Map the offset to a register id and vector word index
    always_comb begin
        vidx = VIDX_W'((req_addr - ADDR_W'(OFF_RVB)) >> 2);
        if      (req_addr == ADDR_W'(OFF_ERRCTL))  rid = RID_ERRCTL;
        else if (req_addr == ADDR_W'(OFF_ISR))     rid = RID_ISR;
        else if (req_addr == ADDR_W'(OFF_IMR))     rid = RID_IMR;
        else if (req_addr == ADDR_W'(OFF_IEN))     rid = RID_IEN;
        else if (req_addr == ADDR_W'(OFF_IDS))     rid = RID_IDS;
        else if (req_addr == ADDR_W'(OFF_CFG0))    rid = RID_CFG0;
        else if (req_addr == ADDR_W'(OFF_CFG1))    rid = RID_CFG1;
        else if (req_addr == ADDR_W'(OFF_COH))     rid = RID_COH;
        else if (req_addr == ADDR_W'(OFF_SNOOP))   rid = RID_SNOOP;
        else if (req_addr == ADDR_W'(OFF_PWRCTL))  rid = RID_PWRCTL;
        else if (req_addr == ADDR_W'(OFF_PWRSTAT)) rid = RID_PWRSTAT;
        else if (req_addr >= ADDR_W'(OFF_RVB) && req_addr < ADDR_W'(RVB_END))
                                                   rid = RID_RVB;
        else                                       rid = RID_NONE;
    end
endmodule

// File: rtl/cc_vector_regs.sv
// Module: per-core reset vector words, low/high pairs with core 0 first.
// Assumes vidx is valid whenever wr_en is high.
module cc_vector_regs
    import cc_pkg::*;
#(
    parameter int NCORES = 4,
    localparam int NWORDS = 2 * NCORES,
    localparam int VIDX_W = $clog2(NWORDS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [VIDX_W-1:0]        vidx,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rd_word,
    output logic [NCORES*64-1:0]     rvbar
);
    logic [DATA_W-1:0] words [NWORDS];

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        localparam logic [DATA_W-1:0] WRST = (w % 2 == 0) ? RST_RVB_LO : '0;
        cc_word_reg #(.W(DATA_W), .RST(WRST)) u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en && (vidx == VIDX_W'(w))),
            .d     (wdata),
            .q     (words[w])
        );
    end

    for (genvar c = 0; c < NCORES; c++) begin : g_core
        assign rvbar[c*64 +: 64] = {words[2*c+1], words[2*c]};
    end

    // Select the addressed word for readback
    always_comb rd_word = words[vidx];
endmodule

// File: rtl/cc_power_ctrl.sv
// Module: per-core power-down request and gated idle indication.
// Assumes core_wfi_in is synchronous to clk; it is captured once per cycle.
module cc_power_ctrl #(
    parameter int NCORES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [NCORES-1:0] wdata,
    input  logic [NCORES-1:0] core_wfi_in,
    output logic [NCORES-1:0] pd_req,
    output logic [NCORES-1:0] wfi_out
);
    logic [NCORES-1:0] wfi_q;

    // Store the power-down request written by software
    always_ff @(posedge clk) begin
        if (!rst_n)     pd_req <= '0;
        else if (wr_en) pd_req <= wdata;
    end

    // Capture the per-core idle state
    always_ff @(posedge clk) begin
        if (!rst_n) wfi_q <= '0;
        else        wfi_q <= core_wfi_in;
    end

    // Idle output only for cores that are requested to power down
    always_comb wfi_out = pd_req & wfi_q;
endmodule

// File: rtl/cc_irq_ctrl.sv
// Module: single-source error interrupt with status, mask, enable and disable.
// Assumes enable and disable writes never arrive in the same cycle.
module cc_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic err_pulse,
    input  logic wr_isr,
    input  logic wr_ien,
    input  logic wr_ids,
    input  logic wbit,
    output logic isr_q,
    output logic imr_q,
    output logic irq
);
    // Status bit: hardware set has priority over write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)               isr_q <= 1'b0;
        else if (err_pulse)       isr_q <= 1'b1;
        else if (wr_isr && wbit)  isr_q <= 1'b0;
    end

    // Mask bit: changed only through the disable and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n)               imr_q <= 1'b1;
        else if (wr_ids && wbit)  imr_q <= 1'b1;
        else if (wr_ien && wbit)  imr_q <= 1'b0;
    end

    // Interrupt line for a pending, unmasked source
    always_comb irq = isr_q && !imr_q;
endmodule

// File: rtl/cluster_ctrl_regs.sv
// Module: top of the cluster control register block.
// Assumes a single-request-per-cycle bus with reads answered one cycle later.
module cluster_ctrl_regs
    import cc_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [3:0]            req_be,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [31:0]           req_wdata,
    output logic                  rd_valid,
    output logic [31:0]           rd_data,
    input  logic                  err_pulse,
    input  logic [NCORES-1:0]     core_wfi_in,
    output logic [NCORES-1:0]     wfi_out,
    output logic [NCORES-1:0]     pwr_status,
    output logic                  irq,
    output logic [NCORES*64-1:0]  core_rvbar
);
    localparam int VIDX_W = $clog2(2 * NCORES);

    logic              wr_ok, rd_ok, rd_req;
    reg_id_e           rid;
    logic [VIDX_W-1:0] vidx;
    logic [31:0]       q_errctl, q_cfg0, q_cfg1, q_coh, q_snoop, q_vec;
    logic [NCORES-1:0] pd_req;
    logic              isr_q, imr_q;
    logic [31:0]       rd_mux;

    cc_bus_decode #(.NCORES(NCORES), .ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_be    (req_be),
        .req_addr  (req_addr),
        .wr_ok     (wr_ok),
        .rd_ok     (rd_ok),
        .rd_req    (rd_req),
        .rid       (rid),
        .vidx      (vidx)
    );

    cc_word_reg #(.W(32), .RST('0)) u_errctl (
        .clk(clk), .rst_n(rst_n), .we(wr_ok && rid == RID_ERRCTL),
        .d(req_wdata), .q(q_errctl));
    cc_word_reg #(.W(32), .RST(RST_CFG0)) u_cfg0 (
        .clk(clk), .rst_n(rst_n), .we(wr_ok && rid == RID_CFG0),
        .d(req_wdata), .q(q_cfg0));
    cc_word_reg #(.W(32), .RST('0)) u_cfg1 (
        .clk(clk), .rst_n(rst_n), .we(wr_ok && rid == RID_CFG1),
        .d(req_wdata), .q(q_cfg1));
    cc_word_reg #(.W(32), .RST(RST_COH)) u_coh (
        .clk(clk), .rst_n(rst_n), .we(wr_ok && rid == RID_COH),
        .d(req_wdata), .q(q_coh));
    cc_word_reg #(.W(32), .RST('0)) u_snoop (
        .clk(clk), .rst_n(rst_n), .we(wr_ok && rid == RID_SNOOP),
        .d(req_wdata), .q(q_snoop));

    cc_vector_regs #(.NCORES(NCORES)) u_vec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok && rid == RID_RVB),
        .vidx    (vidx),
        .wdata   (req_wdata),
        .rd_word (q_vec),
        .rvbar   (core_rvbar)
    );

    cc_power_ctrl #(.NCORES(NCORES)) u_pwr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_ok && rid == RID_PWRCTL),
        .wdata       (req_wdata[NCORES-1:0]),
        .core_wfi_in (core_wfi_in),
        .pd_req      (pd_req),
        .wfi_out     (wfi_out)
    );

    cc_irq_ctrl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_pulse (err_pulse),
        .wr_isr    (wr_ok && rid == RID_ISR),
        .wr_ien    (wr_ok && rid == RID_IEN),
        .wr_ids    (wr_ok && rid == RID_IDS),
        .wbit      (req_wdata[0]),
        .isr_q     (isr_q),
        .imr_q     (imr_q),
        .irq       (irq)
    );

    assign pwr_status = pd_req;

    // Select readback data for the addressed register
    always_comb begin
        case (rid)
            RID_ERRCTL:  rd_mux = q_errctl;
            RID_ISR:     rd_mux = 32'(isr_q);
            RID_IMR:     rd_mux = 32'(imr_q);
            RID_CFG0:    rd_mux = q_cfg0;
            RID_CFG1:    rd_mux = q_cfg1;
            RID_RVB:     rd_mux = q_vec;
            RID_COH:     rd_mux = q_coh;
            RID_SNOOP:   rd_mux = q_snoop;
            RID_PWRCTL:  rd_mux = 32'(pd_req);
            RID_PWRSTAT: rd_mux = 32'(wfi_out);
            default:     rd_mux = '0;
        endcase
    end

    // Register the read response one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            rd_data  <= rd_ok ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/cluster_ctrl_regs_checker.sv
// Module: property checker for the cluster control register block, bound to the top.
// Assumes synchronous active-low reset; all properties are disabled during reset.
module cluster_ctrl_regs_checker #(
    parameter int NCORES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [3:0]        req_be,
    input logic              err_pulse,
    input logic [NCORES-1:0] wfi_out,
    input logic [NCORES-1:0] pwr_status,
    input logic              irq,
    input logic              rd_valid,
    input logic              isr_bit,
    input logic              imr_bit
);
    p_wfi_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((wfi_out & ~pwr_status) == '0));

    p_err_sets_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> isr_bit);

    p_irq_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (isr_bit && !imr_bit));

    p_rd_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    p_no_spurious_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);

    p_partial_wr_pwr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_be != 4'hF) |=> $stable(pwr_status));

    p_partial_wr_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_be != 4'hF) |=> $stable(imr_bit));
endmodule

bind cluster_ctrl_regs cluster_ctrl_regs_checker #(.NCORES(NCORES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_be     (req_be),
    .err_pulse  (err_pulse),
    .wfi_out    (wfi_out),
    .pwr_status (pwr_status),
    .irq        (irq),
    .rd_valid   (rd_valid),
    .isr_bit    (isr_q),
    .imr_bit    (imr_q)
);

// File: tb/cluster_ctrl_regs_test.sv
// Bench: vector table walk, then directed reset and corner-case tests.
module cluster_ctrl_regs_test;
    localparam int NCORES = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [3:0]   req_be = 4'hF;
    logic [7:0]   req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         rd_valid;
    logic [31:0]  rd_data;
    logic         err_pulse = 1'b0;
    logic [3:0]   core_wfi_in = '0;
    logic [3:0]   wfi_out;
    logic [3:0]   pwr_status;
    logic         irq;
    logic [255:0] core_rvbar;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cluster_ctrl_regs #(.NCORES(NCORES), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_be(req_be), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .err_pulse(err_pulse),
        .core_wfi_in(core_wfi_in), .wfi_out(wfi_out), .pwr_status(pwr_status),
        .irq(irq), .core_rvbar(core_rvbar)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 32;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'h00, 32'h0, 32'h0000_0000, 8'd1},   // R1 error control
        '{1'b0, 8'h20, 32'h0, 32'h0000_0F0F, 8'd1},   // R1 config 0
        '{1'b0, 8'h60, 32'h0, 32'h000F_000F, 8'd1},   // R1 coherency
        '{1'b0, 8'h40, 32'h0, 32'hFFFF_0000, 8'd1},   // R1 core0 low
        '{1'b0, 8'h5C, 32'h0, 32'h0000_0000, 8'd1},   // R1 core3 high
        '{1'b0, 8'h14, 32'h0, 32'h0000_0001, 8'd1},   // R1 mask
        '{1'b1, 8'h24, 32'hA5A5_1234, 32'h0, 8'd8},
        '{1'b0, 8'h24, 32'h0, 32'hA5A5_1234, 8'd8},   // R8
        '{1'b1, 8'h80, 32'hDEAD_BEEF, 32'h0, 8'd8},
        '{1'b0, 8'h80, 32'h0, 32'hDEAD_BEEF, 8'd8},   // R8
        '{1'b1, 8'h00, 32'h0000_00FF, 32'h0, 8'd8},
        '{1'b0, 8'h00, 32'h0, 32'h0000_00FF, 8'd8},   // R8
        '{1'b1, 8'h48, 32'h1111_2222, 32'h0, 8'd2},
        '{1'b1, 8'h4C, 32'h3333_4444, 32'h0, 8'd2},
        '{1'b0, 8'h48, 32'h0, 32'h1111_2222, 8'd2},   // R2
        '{1'b0, 8'h4C, 32'h0, 32'h3333_4444, 8'd2},   // R2
        '{1'b1, 8'h14, 32'h0, 32'h0, 8'd7},
        '{1'b0, 8'h14, 32'h0, 32'h0000_0001, 8'd7},   // R7 mask write ignored
        '{1'b1, 8'h18, 32'h1, 32'h0, 8'd7},
        '{1'b0, 8'h18, 32'h0, 32'h0000_0000, 8'd7},   // R7 enable reads zero
        '{1'b0, 8'h14, 32'h0, 32'h0000_0000, 8'd7},   // R7 mask cleared
        '{1'b1, 8'h1C, 32'h1, 32'h0, 8'd7},
        '{1'b0, 8'h1C, 32'h0, 32'h0000_0000, 8'd7},   // R7 disable reads zero
        '{1'b0, 8'h14, 32'h0, 32'h0000_0001, 8'd7},   // R7 mask set
        '{1'b1, 8'h30, 32'hFFFF_FFFF, 32'h0, 8'd10},
        '{1'b0, 8'h30, 32'h0, 32'h0000_0000, 8'd10},  // R10
        '{1'b1, 8'h90, 32'hFFFF_FFF5, 32'h0, 8'd3},
        '{1'b0, 8'h90, 32'h0, 32'h0000_0005, 8'd3},   // R3
        '{1'b1, 8'h94, 32'hFFFF_FFFF, 32'h0, 8'd11},
        '{1'b0, 8'h94, 32'h0, 32'h0000_0000, 8'd11},  // R11
        '{1'b1, 8'h90, 32'h0, 32'h0, 8'd3},
        '{1'b0, 8'h90, 32'h0, 32'h0000_0000, 8'd3}    // R3
    };

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d,
                             input logic [3:0] be);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_be = 4'hF;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [3:0] be,
                            output logic [31:0] d, output logic v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
        @(posedge clk);
        @(negedge clk);
        d = rd_data; v = rd_valid;
        req_valid = 1'b0; req_be = 4'hF;
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic        v;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: outputs after reset
        check("R1", "irq", 64'(irq), 64'h0);
        check("R1", "wfi_out", 64'(wfi_out), 64'h0);
        check("R1", "pwr_status", 64'(pwr_status), 64'h0);
        check("R1", "core0 vector", core_rvbar[63:0], 64'h0000_0000_FFFF_0000);
        check("R1", "core3 vector", core_rvbar[255:192], 64'h0000_0000_FFFF_0000);

        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].wr) begin
                bus_write(VECS[i].addr, VECS[i].data, 4'hF);
            end else begin
                bus_read(VECS[i].addr, 4'hF, d, v);
                check($sformatf("R%0d", VECS[i].req),
                      $sformatf("read %h", VECS[i].addr), 64'(d), 64'(VECS[i].exp));
            end
        end

        // R2: concatenated vector output for core 1
        check("R2", "core1 vector", core_rvbar[127:64], 64'h3333_4444_1111_2222);

        // R12: acknowledge timing
        bus_read(8'h20, 4'hF, d, v);
        check("R12", "rd_valid after read", 64'(v), 64'h1);
        step();
        check("R12", "rd_valid idle", 64'(rd_valid), 64'h0);

        // R3, R4, R11: power request gating idle inputs
        bus_write(8'h90, 32'h5, 4'hF);
        check("R3", "pwr_status", 64'(pwr_status), 64'h5);
        core_wfi_in = 4'b0011;
        check("R4", "wfi_out before capture", 64'(wfi_out), 64'h0);
        step();
        check("R4", "wfi_out gated", 64'(wfi_out), 64'h1);
        bus_read(8'h94, 4'hF, d, v);
        check("R11", "power status read", 64'(d), 64'h1);
        core_wfi_in = 4'b1111;
        step();
        check("R4", "wfi_out all idle", 64'(wfi_out), 64'h5);
        core_wfi_in = 4'b0000;
        step();
        check("R4", "wfi_out cleared", 64'(wfi_out), 64'h0);

        // R5, R6: masked pulse, enable, clear, same-cycle set and clear
        @(negedge clk); err_pulse = 1'b1;
        @(posedge clk); @(negedge clk); err_pulse = 1'b0;
        check("R6", "irq while masked", 64'(irq), 64'h0);
        bus_read(8'h10, 4'hF, d, v);
        check("R5", "status set", 64'(d), 64'h1);
        bus_write(8'h18, 32'h1, 4'hF);
        check("R6", "irq after enable", 64'(irq), 64'h1);
        bus_write(8'h10, 32'h1, 4'hF);
        check("R5", "irq after clear", 64'(irq), 64'h0);
        bus_read(8'h10, 4'hF, d, v);
        check("R5", "status cleared", 64'(d), 64'h0);
        @(negedge clk);
        err_pulse = 1'b1; req_valid = 1'b1; req_write = 1'b1;
        req_addr = 8'h10; req_wdata = 32'h1; req_be = 4'hF;
        @(posedge clk); @(negedge clk);
        err_pulse = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        check("R5", "set wins over clear", 64'(irq), 64'h1);
        bus_write(8'h1C, 32'h1, 4'hF);
        check("R6", "irq after disable", 64'(irq), 64'h0);
        bus_write(8'h10, 32'h1, 4'hF);

        // R9: partial and unaligned accesses
        bus_write(8'h24, 32'h0, 4'h7);
        bus_read(8'h24, 4'hF, d, v);
        check("R9", "partial write ignored", 64'(d), 64'hA5A5_1234);
        bus_read(8'h24, 4'h7, d, v);
        check("R9", "partial read zero", 64'(d), 64'h0);
        check("R12", "partial read acknowledged", 64'(v), 64'h1);
        bus_write(8'h25, 32'h0, 4'hF);
        bus_read(8'h24, 4'hF, d, v);
        check("R9", "unaligned write ignored", 64'(d), 64'hA5A5_1234);
        bus_write(8'h90, 32'hF, 4'h1);
        check("R9", "partial power write ignored", 64'(pwr_status), 64'h5);

        // R1: reset in mid-run
        bus_write(8'h20, 32'h1234_5678, 4'hF);
        @(negedge clk); rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        check("R1", "pwr_status after reset", 64'(pwr_status), 64'h0);
        check("R1", "core1 vector after reset", core_rvbar[127:64], 64'h0000_0000_FFFF_0000);
        bus_read(8'h20, 4'hF, d, v);
        check("R1", "config 0 after reset", 64'(d), 64'h0F0F);
        bus_read(8'h14, 4'hF, d, v);
        check("R1", "mask after reset", 64'(d), 64'h1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule